// File: doc/BRIEF.md
# UART Receive Buffer with FIFO Bypass

This block is the receive half of a UART register interface. Bytes arrive from a deserializer over a valid/ready handshake and are held until the CPU reads them through a receive holding register. A configuration level chooses between two storage modes: a 16-entry first-in first-out queue, or a single-byte holding register that bypasses the queue.

The block publishes the number of further bytes it can take, and drives the upstream ready from that number. It keeps a data-ready status flag. Every CPU read, including a read that finds the buffer empty, produces a one-cycle wake pulse so that a stalled sender can try again. A change of mode empties both storage paths. The read result is a register, so it keeps the last byte delivered.

Top module: `uart_rx_buffer`

## Requirements
- R1: After synchronous reset, with `fifo_en_i` low, `data_ready_o` is 0, `rd_data_o` is 0x00, `rd_wake_o` is 0, `space_o` is 1 and `in_ready_o` is 1.
- R2: `fifo_en_i` high selects queue mode and low selects single-byte mode. While `fifo_en_i` differs from the mode in force, `space_o` is 0 and no byte is accepted. At the next clock edge the new mode takes effect, and both the queue and the holding byte are emptied, so `data_ready_o` is 0 afterwards.
- R3: In queue mode, `space_o` equals DEPTH minus the number of stored bytes.
- R4: In queue mode, a read pops the oldest stored byte, and `rd_data_o` shows it from the clock edge that takes the read. Bytes come out in arrival order.
- R5: In queue mode, `data_ready_o` is 1 exactly while the queue holds at least one byte.
- R6: In single-byte mode, `space_o` is 1 while `data_ready_o` is clear and 0 while it is set.
- R7: In single-byte mode, a read returns the held byte on `rd_data_o` and clears `data_ready_o`.
- R8: `in_ready_o` is 1 exactly when `space_o` is non-zero. A byte is taken only at a clock edge where both `in_valid_i` and `in_ready_o` are 1. A byte offered while not ready is not stored.
- R9: `rd_wake_o` is 1 in the cycle after every cycle in which `rd_en_i` is 1, and 0 otherwise.
- R10: A read of an empty buffer leaves `rd_data_o`, `data_ready_o` and `space_o` unchanged.
- R11: In queue mode, a read and an accepted byte in the same cycle both take effect, so the stored count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en_i | input | 1 | Mode select: 1 selects the queue, 0 selects the single-byte register |
| in_valid_i | input | 1 | Upstream byte valid |
| in_data_i | input | 8 | Upstream byte |
| in_ready_o | output | 1 | Buffer can take a byte this cycle |
| rd_en_i | input | 1 | CPU read strobe for the holding register |
| rd_data_o | output | 8 | Last byte delivered to the CPU |
| data_ready_o | output | 1 | At least one byte waiting |
| space_o | output | 5 | Number of further bytes that can be accepted |
| rd_wake_o | output | 1 | One-cycle pulse after each read |

## Verification
The bench builds the block with its defaults: an 8-bit data width and a 16-entry queue. At this depth, filling the queue to the brim and draining it in order fits in a few dozen cycles. That brings the full-queue refusal, the read-plus-push at a near-full level and the last-entry drain all within reach. Single-byte mode is driven from a vector table that covers refusal while holding a byte, a read on the same cycle as an offer, and empty reads. Mode switches are made with data present in both directions, to show the flush.

// File: rtl/uart_rxb_pkg.sv
// Package: shared types for the UART receive buffer.
// Assumes: nothing beyond a 1-bit mode encoding.
package uart_rxb_pkg;

    // Storage mode in force.
    typedef enum logic {
        MODE_HOLD = 1'b0,
        MODE_FIFO = 1'b1
    } rxb_mode_e;

endpackage

// File: rtl/rxb_fifo.sv
// Module: rxb_fifo
// Ring-buffer queue of DEPTH entries with an occupancy count.
// Assumes: the caller never pushes when full or pops when empty, and
// flush has priority over push and pop.
module rxb_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    // Store the incoming byte at the write pointer.
    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Advance the pointers and the count, or clear them on reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Present the oldest entry.
    always_comb begin
        head = mem[rd_ptr];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CNT_W'(DEPTH)));                       // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));                                  // R4
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));                                // R2

endmodule

// File: rtl/rxb_hold.sv
// Module: rxb_hold
// Single-byte holding register with a full flag.
// Assumes: load only when empty, clear only when full, and flush wins.
module rxb_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              clear,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    // Capture a byte, or drop the flag on a read or a flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (flush) begin
            full <= 1'b0;
        end else if (load) begin
            full <= 1'b1;
            data <= load_data;
        end else if (clear) begin
            full <= 1'b0;
        end
    end

    AST_HOLD_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !full);                                         // R6
    AST_HOLD_CLEAR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> full);                                         // R7

endmodule

// File: rtl/rxb_ctrl.sv
// Module: rxb_ctrl
// Tracks the mode in force, detects a mode switch, computes the
// accept capacity and produces the post-read wake pulse.
// Assumes: fifo_count and hold_full come from the storage of this block.
module rxb_ctrl
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_fifo_en,
    input  logic             rd_en,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             hold_full,
    output rxb_mode_e        mode,
    output logic             switching,
    output logic [CNT_W-1:0] space,
    output logic             wake
);

    // Follow the requested mode one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_HOLD;
        end else begin
            mode <= cfg_fifo_en ? MODE_FIFO : MODE_HOLD;
        end
    end

    // Raise the wake pulse after every read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake <= 1'b0;
        end else begin
            wake <= rd_en;
        end
    end

    // Flag a pending mode change.
    always_comb begin
        switching = (cfg_fifo_en != (mode == MODE_FIFO));
    end

    // Compute how many more bytes can be taken.
    always_comb begin
        if (switching) begin
            space = '0;
        end else if (mode == MODE_FIFO) begin
            space = CNT_W'(DEPTH) - fifo_count;
        end else begin
            space = hold_full ? '0 : CNT_W'(1);
        end
    end

    AST_SPACE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        space <= CNT_W'(DEPTH));                                 // R3

endmodule

// File: rtl/uart_rx_buffer.sv
// Module: uart_rx_buffer (top)
// Receive buffer of a UART: accepts bytes over valid/ready, stores them
// in a queue or a single-byte register, and returns them on CPU reads.
// Assumes: rd_en_i is a one-cycle strobe per read access.
module uart_rx_buffer
    import uart_rxb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en_i,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] in_data_i,
    output logic              in_ready_o,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              data_ready_o,
    output logic [CNT_W-1:0]  space_o,
    output logic              rd_wake_o
);

    rxb_mode_e         mode;
    logic              switching;
    logic [CNT_W-1:0]  fifo_count;
    logic [DATA_W-1:0] fifo_head;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              accept;
    logic              rd_take;
    logic              fifo_push;
    logic              fifo_pop;
    logic              hold_load;
    logic              hold_clear;

    rxb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_fifo_en (fifo_en_i),
        .rd_en       (rd_en_i),
        .fifo_count  (fifo_count),
        .hold_full   (hold_full),
        .mode        (mode),
        .switching   (switching),
        .space       (space_o),
        .wake        (rd_wake_o)
    );

    rxb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (switching),
        .push      (fifo_push),
        .push_data (in_data_i),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .count     (fifo_count)
    );

    rxb_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (switching),
        .load      (hold_load),
        .load_data (in_data_i),
        .clear     (hold_clear),
        .full      (hold_full),
        .data      (hold_data)
    );

    // Derive the handshake and route pushes and pops to the active storage.
    always_comb begin
        in_ready_o = (space_o != '0);
        accept     = in_valid_i && in_ready_o;
        rd_take    = rd_en_i && !switching;
        fifo_push  = (mode == MODE_FIFO) && accept;
        fifo_pop   = (mode == MODE_FIFO) && rd_take && (fifo_count != '0);
        hold_load  = (mode == MODE_HOLD) && accept;
        hold_clear = (mode == MODE_HOLD) && rd_take && hold_full;
    end

    // Report whether a byte is waiting in the active storage.
    always_comb begin
        data_ready_o = (mode == MODE_FIFO) ? (fifo_count != '0) : hold_full;
    end

    // Latch the byte delivered by a read; empty reads keep the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
        end else if (fifo_pop) begin
            rd_data_o <= fifo_head;
        end else if (hold_clear) begin
            rd_data_o <= hold_data;
        end
    end

    AST_WAKE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_wake_o);                                  // R9
    AST_EMPTY_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !data_ready_o) |=> $stable(rd_data_o));      // R10
    AST_HOLD_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        (!switching && mode == MODE_HOLD) |->
            (space_o == (data_ready_o ? CNT_W'(0) : CNT_W'(1))));  // R6
    AST_SWITCH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        switching |=> !data_ready_o);                            // R2
    AST_NO_TAKE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        switching |-> !in_ready_o);                              // R2

endmodule

// File: tb/sim_uart_rx_buffer.sv
module sim_uart_rx_buffer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en_i = 1'b0;
    logic       in_valid_i = 1'b0;
    logic [7:0] in_data_i = 8'h00;
    logic       in_ready_o;
    logic       rd_en_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       data_ready_o;
    logic [4:0] space_o;
    logic       rd_wake_o;

    int n_checks = 0;
    int n_fail   = 0;

    // Fields: [23] valid, [22:15] data, [14] read, [13:9] exp space,
    // [8] exp data_ready, [7:0] exp rd_data (all after the edge).
    localparam logic [23:0] TBL [0:7] = '{
        {1'b1, 8'hA5, 1'b0, 5'd0, 1'b1, 8'h00},
        {1'b1, 8'h3C, 1'b0, 5'd0, 1'b1, 8'h00},
        {1'b0, 8'h00, 1'b1, 5'd1, 1'b0, 8'hA5},
        {1'b0, 8'h00, 1'b1, 5'd1, 1'b0, 8'hA5},
        {1'b1, 8'h3C, 1'b0, 5'd0, 1'b1, 8'hA5},
        {1'b1, 8'h77, 1'b1, 5'd1, 1'b0, 8'h3C},
        {1'b1, 8'h77, 1'b0, 5'd0, 1'b1, 8'h3C},
        {1'b0, 8'h00, 1'b1, 5'd1, 1'b0, 8'h77}
    };

    always #4 clk = ~clk;

    uart_rx_buffer u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_en_i    (fifo_en_i),
        .in_valid_i   (in_valid_i),
        .in_data_i    (in_data_i),
        .in_ready_o   (in_ready_o),
        .rd_en_i      (rd_en_i),
        .rd_data_o    (rd_data_o),
        .data_ready_o (data_ready_o),
        .space_o      (space_o),
        .rd_wake_o    (rd_wake_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 space", 32'(space_o), 32'd1);
        chk("R1 in_ready", 32'(in_ready_o), 32'd1);
        chk("R1 data_ready", 32'(data_ready_o), 32'd0);
        chk("R1 rd_data", 32'(rd_data_o), 32'h00);
        chk("R1 wake", 32'(rd_wake_o), 32'd0);

        // Single-byte mode vector walk: R6 R7 R8 R9 R10
        for (int i = 0; i < 8; i++) begin
            logic [23:0] v;
            v = TBL[i];
            in_valid_i = v[23];
            in_data_i  = v[22:15];
            rd_en_i    = v[14];
            step();
            chk("R6 space", 32'(space_o), 32'(v[13:9]));
            chk("R7 data_ready", 32'(data_ready_o), 32'(v[8]));
            chk("R7 rd_data", 32'(rd_data_o), 32'(v[7:0]));
            chk("R9 wake", 32'(rd_wake_o), 32'(v[14]));
            chk("R8 in_ready", 32'(in_ready_o), 32'(space_o != 5'd0));
        end
        in_valid_i = 1'b0;
        rd_en_i    = 1'b0;

        // Mode switch with a held byte: R2
        in_valid_i = 1'b1;
        in_data_i  = 8'h5A;
        step();
        in_valid_i = 1'b0;
        chk("R7 loaded", 32'(data_ready_o), 32'd1);
        fifo_en_i = 1'b1;
        #1;
        chk("R2 space during switch", 32'(space_o), 32'd0);
        chk("R2 in_ready during switch", 32'(in_ready_o), 32'd0);
        step();
        chk("R2 flushed", 32'(data_ready_o), 32'd0);
        chk("R3 empty space", 32'(space_o), 32'd16);

        // Fill the queue: R3 R5
        for (int k = 0; k < 16; k++) begin
            in_valid_i = 1'b1;
            in_data_i  = 8'h10 + 8'(k);
            step();
            chk("R3 space fill", 32'(space_o), 32'(15 - k));
            chk("R5 data_ready fill", 32'(data_ready_o), 32'd1);
        end
        in_data_i = 8'hEE;
        #1;
        chk("R8 full not ready", 32'(in_ready_o), 32'd0);
        step();
        chk("R8 full refused", 32'(space_o), 32'd0);
        in_valid_i = 1'b0;

        // Drain with one read-plus-push: R4 R11
        rd_en_i = 1'b1;
        step();
        chk("R4 first out", 32'(rd_data_o), 32'h10);
        chk("R3 after pop", 32'(space_o), 32'd1);
        in_valid_i = 1'b1;
        in_data_i  = 8'h60;
        step();
        in_valid_i = 1'b0;
        chk("R11 rd_data", 32'(rd_data_o), 32'h11);
        chk("R11 space", 32'(space_o), 32'd1);
        for (int j = 2; j < 16; j++) begin
            step();
            chk("R4 order", 32'(rd_data_o), 32'(8'h10 + 8'(j)));
        end
        step();
        chk("R4 last", 32'(rd_data_o), 32'h60);
        chk("R5 empty", 32'(data_ready_o), 32'd0);
        chk("R3 empty again", 32'(space_o), 32'd16);

        // Empty read in queue mode: R9 R10
        step();
        chk("R10 rd_data", 32'(rd_data_o), 32'h60);
        chk("R10 space", 32'(space_o), 32'd16);
        chk("R10 data_ready", 32'(data_ready_o), 32'd0);
        chk("R9 wake empty read", 32'(rd_wake_o), 32'd1);
        rd_en_i = 1'b0;
        step();
        chk("R9 wake low", 32'(rd_wake_o), 32'd0);

        // Switch back with data queued: R2 R6
        in_valid_i = 1'b1;
        in_data_i  = 8'hA1;
        step();
        in_data_i  = 8'hA2;
        step();
        in_valid_i = 1'b0;
        chk("R3 two stored", 32'(space_o), 32'd14);
        fifo_en_i = 1'b0;
        #1;
        chk("R2 space during switch back", 32'(space_o), 32'd0);
        step();
        chk("R2 flushed queue", 32'(data_ready_o), 32'd0);
        chk("R6 space hold empty", 32'(space_o), 32'd1);
        rd_en_i = 1'b1;
        step();
        rd_en_i = 1'b0;
        chk("R10 read after flush", 32'(rd_data_o), 32'h60);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule